// File: doc/BRIEF.md
# Fixed-Priority Vectored Interrupt Controller

This block sits next to a small processor core and decides when the core is interrupted. Each event source (timer overflows, external pins and the like) raises a request that is caught in a pending flag. A source may interrupt only when its mask bit is set and a single global enable is on. When at least one pending, unmasked source exists while the global enable is on, the controller picks the source with the lowest index and gives the core a vector address for it. The vector entries are two bytes apart.

When a source is accepted, the controller clears that source's pending flag and turns the global enable off, so service routines do not nest. A return strobe from the core turns the global enable back on. Software controls the global enable through separate set and clear strobes. A request that arrives while interrupts are held off stays pending and is taken after the return.

Top module: `vec_irq_ctrl`

## Requirements
- R1: During reset and in the first cycle after the internal reset is released, `gie_o` is 0, `pend_o` is all zeros, `irq_o` is 0 and `irq_vec_o` equals `VEC_BASE`.
- R2: A cycle with `src_req_i[k]` high sets `pend_o[k]` from the next cycle onward. The flag stays set until source k is accepted, including while `gie_o` is 0 or the source is masked.
- R3: A source is accepted at a clock edge only if `gie_o` is 1 and `pend_o[k] & src_mask_i[k]` is 1 before that edge. No other condition leads to acceptance.
- R4: Among the pending, unmasked sources, the one with the lowest index k is accepted.
- R5: On acceptance of source k, `irq_vec_o` becomes `VEC_BASE + 2*k`.
- R6: Acceptance drives `irq_o` high for exactly one cycle and clears `gie_o` at the same edge.
- R7: Acceptance clears only the winner's pending flag. A new request from the winner in the acceptance cycle leaves its flag set.
- R8: A cycle with `irq_ret_i` high and no acceptance sets `gie_o` at the next edge, unless `gie_clr_i` is also high.
- R9: `gie_set_i` sets `gie_o` and `gie_clr_i` clears it. When both are high together, the clear wins.
- R10: `irq_o` and `irq_vec_o` are registered. They change one edge after the acceptance decision, and `irq_vec_o` holds its value until the next acceptance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| src_req_i | input | N_SRC | Request event per source, sampled every cycle |
| src_mask_i | input | N_SRC | Per-source enable (1 = may interrupt) |
| gie_set_i | input | 1 | Strobe: turn the global enable on |
| gie_clr_i | input | 1 | Strobe: turn the global enable off |
| irq_ret_i | input | 1 | Strobe: core has returned from a service routine |
| irq_o | output | 1 | One-cycle interrupt request to the core |
| irq_vec_o | output | VEC_W | Vector address of the last accepted source |
| gie_o | output | 1 | Current global enable |
| pend_o | output | N_SRC | Pending flags |

## Verification
A pending flag that is held wrong shows at `pend_o` on the next cycle. The same fault also delays or duplicates an `irq_o` pulse as soon as the global enable is on. A wrong priority choice or a wrong vector calculation shows on `irq_vec_o` one cycle after the acceptance edge. A global enable that recovers wrongly is visible on `gie_o` one cycle after the strobe, and it shows up as a second `irq_o` pulse with no return in between.

// File: rtl/vic_pkg.sv
package vic_pkg;
  parameter int unsigned VIC_NSRC_DEF = 8;
  parameter int unsigned VIC_VW_DEF   = 16;

  typedef enum logic [1:0] {
    GIE_HOLD = 2'd0,
    GIE_ON   = 2'd1,
    GIE_OFF  = 2'd2
  } gie_op_e;
endpackage

// File: rtl/vic_pend_bank.sv
module vic_pend_bank #(
  parameter int unsigned N = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] set_i,
  input  logic [N-1:0] clr_i,
  output logic [N-1:0] pend_o
);
  logic [N-1:0] pend_q, pend_d;

  // a fresh event outranks the clear of an accepted source
  always_comb begin
    pend_d = (pend_q & ~clr_i) | set_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pend_q <= '0;
    else        pend_q <= pend_d;
  end

  assign pend_o = pend_q;
endmodule

// File: rtl/vic_prio_pick.sv
module vic_prio_pick #(
  parameter int unsigned N  = 8,
  parameter int unsigned IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]  req_i,
  output logic          any_o,
  output logic [N-1:0]  onehot_o,
  output logic [IW-1:0] idx_o
);
  logic [N-1:0] blocked;

  assign blocked[0]  = 1'b0;
  assign onehot_o[0] = req_i[0];

  for (genvar i = 1; i < N; i++) begin : g_chain
    assign blocked[i]  = blocked[i-1] | req_i[i-1];
    assign onehot_o[i] = req_i[i] & ~blocked[i];
  end

  assign any_o = |req_i;

  always_comb begin
    idx_o = '0;
    for (int unsigned i = 0; i < N; i++) begin
      if (onehot_o[i]) idx_o = idx_o | IW'(i);
    end
  end
endmodule

// File: rtl/vic_gie_reg.sv
module vic_gie_reg
  import vic_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic take_i,
  input  logic set_i,
  input  logic clr_i,
  input  logic ret_i,
  output logic gie_o
);
  gie_op_e op;
  logic    gie_q, gie_d;

  always_comb begin
    if (take_i || clr_i)     op = GIE_OFF;
    else if (set_i || ret_i) op = GIE_ON;
    else                     op = GIE_HOLD;
  end

  always_comb begin
    unique case (op)
      GIE_ON:  gie_d = 1'b1;
      GIE_OFF: gie_d = 1'b0;
      default: gie_d = gie_q;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) gie_q <= 1'b0;
    else        gie_q <= gie_d;
  end

  assign gie_o = gie_q;
endmodule

// File: rtl/vec_irq_ctrl.sv
module vec_irq_ctrl
  import vic_pkg::*;
#(
  parameter int unsigned N_SRC    = VIC_NSRC_DEF,
  parameter int unsigned VEC_W    = VIC_VW_DEF,
  parameter logic [VEC_W-1:0] VEC_BASE = 16'h0002
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_SRC-1:0] src_req_i,
  input  logic [N_SRC-1:0] src_mask_i,
  input  logic             gie_set_i,
  input  logic             gie_clr_i,
  input  logic             irq_ret_i,
  output logic             irq_o,
  output logic [VEC_W-1:0] irq_vec_o,
  output logic             gie_o,
  output logic [N_SRC-1:0] pend_o
);
  localparam int unsigned IW = (N_SRC > 1) ? $clog2(N_SRC) : 1;

  // reset: asserted at once, released two edges later
  logic rst_s1, rst_q_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_s1  <= 1'b0;
      rst_q_n <= 1'b0;
    end else begin
      rst_s1  <= 1'b1;
      rst_q_n <= rst_s1;
    end
  end

  logic [N_SRC-1:0] pend, eligible, win_oh, clr_vec;
  logic [IW-1:0]    win_idx;
  logic             any_elig, gie, take;

  vic_pend_bank #(.N(N_SRC)) u_pend (
    .clk(clk), .rst_n(rst_q_n), .set_i(src_req_i), .clr_i(clr_vec), .pend_o(pend)
  );

  assign eligible = pend & src_mask_i;

  vic_prio_pick #(.N(N_SRC), .IW(IW)) u_pick (
    .req_i(eligible), .any_o(any_elig), .onehot_o(win_oh), .idx_o(win_idx)
  );

  assign take    = gie & any_elig;
  assign clr_vec = take ? win_oh : '0;

  vic_gie_reg u_gie (
    .clk(clk), .rst_n(rst_q_n), .take_i(take), .set_i(gie_set_i),
    .clr_i(gie_clr_i), .ret_i(irq_ret_i), .gie_o(gie)
  );

  // output registers: next-state then storage with explicit enable
  logic             irq_q, irq_d;
  logic [VEC_W-1:0] vec_q, vec_d;
  logic             vec_en;

  always_comb begin
    irq_d  = take;
    vec_en = take;
    vec_d  = VEC_BASE + (VEC_W'(win_idx) << 1);
  end

  always_ff @(posedge clk or negedge rst_q_n) begin
    if (!rst_q_n) begin
      irq_q <= 1'b0;
      vec_q <= VEC_BASE;
    end else begin
      irq_q <= irq_d;
      if (vec_en) vec_q <= vec_d;
    end
  end

  assign irq_o     = irq_q;
  assign irq_vec_o = vec_q;
  assign gie_o     = gie;
  assign pend_o    = pend;
endmodule

// File: rtl/vec_irq_ctrl_chk.sv
module vec_irq_ctrl_chk #(
  parameter int unsigned N_SRC    = 8,
  parameter int unsigned VEC_W    = 16,
  parameter logic [VEC_W-1:0] VEC_BASE = 16'h0002
) (
  input logic             clk,
  input logic             rst_q_n,
  input logic [N_SRC-1:0] src_mask_i,
  input logic             gie_set_i,
  input logic             gie_clr_i,
  input logic             irq_ret_i,
  input logic             irq_o,
  input logic [VEC_W-1:0] irq_vec_o,
  input logic             gie_o,
  input logic [N_SRC-1:0] pend_o
);
  localparam logic [VEC_W-1:0] SPAN = VEC_W'(2 * N_SRC);

  assert_no_accept_when_off_R3: assert property (@(posedge clk) disable iff (!rst_q_n)
    !gie_o |=> !irq_o);
  assert_no_accept_when_idle_R3: assert property (@(posedge clk) disable iff (!rst_q_n)
    (gie_o && (pend_o & src_mask_i) == '0) |=> !irq_o);
  assert_accept_when_ready_R3: assert property (@(posedge clk) disable iff (!rst_q_n)
    (gie_o && (pend_o & src_mask_i) != '0) |=> irq_o);
  assert_vec_in_table_R5: assert property (@(posedge clk) disable iff (!rst_q_n)
    irq_o |-> ((irq_vec_o - VEC_BASE) < SPAN) && (irq_vec_o[0] == VEC_BASE[0]));
  assert_gie_off_on_accept_R6: assert property (@(posedge clk) disable iff (!rst_q_n)
    irq_o |-> !gie_o);
  assert_single_pulse_R6: assert property (@(posedge clk) disable iff (!rst_q_n)
    irq_o |=> !irq_o);
  assert_return_enables_R8: assert property (@(posedge clk) disable iff (!rst_q_n)
    (irq_ret_i && !gie_clr_i && !gie_o) |=> gie_o);
  assert_clear_wins_R9: assert property (@(posedge clk) disable iff (!rst_q_n)
    gie_clr_i |=> !gie_o);
  assert_set_enables_R9: assert property (@(posedge clk) disable iff (!rst_q_n)
    (gie_set_i && !gie_clr_i && !gie_o) |=> gie_o);
  assert_vec_holds_R10: assert property (@(posedge clk) disable iff (!rst_q_n)
    !irq_o |-> $stable(irq_vec_o));
endmodule

bind vec_irq_ctrl vec_irq_ctrl_chk #(
  .N_SRC(N_SRC), .VEC_W(VEC_W), .VEC_BASE(VEC_BASE)
) i_chk (
  .clk(clk), .rst_q_n(rst_q_n), .src_mask_i(src_mask_i), .gie_set_i(gie_set_i),
  .gie_clr_i(gie_clr_i), .irq_ret_i(irq_ret_i), .irq_o(irq_o),
  .irq_vec_o(irq_vec_o), .gie_o(gie_o), .pend_o(pend_o)
);

// File: tb/test_vec_irq_ctrl.sv
module test_vec_irq_ctrl;
  localparam int unsigned N    = 8;
  localparam int unsigned VW   = 16;
  localparam logic [VW-1:0] BASE = 16'h0002;

  logic          clk = 1'b0;
  logic          rst_n;
  logic [N-1:0]  src_req, src_mask;
  logic          gset, gclr, gret;
  logic          irq;
  logic [VW-1:0] vec;
  logic          gie;
  logic [N-1:0]  pend;

  always #2 clk = ~clk;

  vec_irq_ctrl #(.N_SRC(N), .VEC_W(VW), .VEC_BASE(BASE)) i_vec_irq_ctrl (
    .clk(clk), .rst_n(rst_n), .src_req_i(src_req), .src_mask_i(src_mask),
    .gie_set_i(gset), .gie_clr_i(gclr), .irq_ret_i(gret),
    .irq_o(irq), .irq_vec_o(vec), .gie_o(gie), .pend_o(pend)
  );

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  // reference state
  logic          m_irq, m_gie;
  logic [VW-1:0] m_vec;
  logic [N-1:0]  m_pend;

  function automatic int lowest(input logic [N-1:0] v);
    for (int i = 0; i < N; i++) if (v[i]) return i;
    return -1;
  endfunction

  function automatic logic [VW-1:0] vec_of(input int k);
    return BASE + VW'(2 * k);
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h t=%0t", tag, act, exp, $time);
    end
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  endtask

  task automatic model_tick();
    logic [N-1:0] el;
    int           w;
    logic         tk;
    el = m_pend & src_mask;
    tk = m_gie && (el != '0);
    w  = lowest(el);
    m_irq = tk;
    if (tk) m_vec = vec_of(w);
    m_pend = (m_pend & ~(tk ? (N'(1) << w) : '0)) | src_req;
    if (tk || gclr)        m_gie = 1'b0;
    else if (gset || gret) m_gie = 1'b1;
  endtask

  task automatic compare_all();
    chk("R3 R6 irq", 32'(irq), 32'(m_irq));
    chk("R4 R5 R10 vector", 32'(vec), 32'(m_vec));
    chk("R8 R9 gie", 32'(gie), 32'(m_gie));
    chk("R2 R7 pending", 32'(pend), 32'(m_pend));
  endtask

  task automatic step(input logic [N-1:0] rq, input logic [N-1:0] mk,
                      input logic s, input logic c, input logic r);
    src_req = rq; src_mask = mk; gset = s; gclr = c; gret = r;
    @(posedge clk);
    model_tick();
    @(negedge clk);
    compare_all();
  endtask

  initial begin
    int cyc = 0;
    while (!done) begin
      @(posedge clk);
      cyc++;
      if (cyc > 150000) begin
        checks++; fails++;
        $display("FAIL watchdog expired actual=%0d expected<150000", cyc);
        finish_run();
      end
    end
  end

  initial begin
    logic [N-1:0] rq, mk;
    void'($urandom(32'd20240611));
    rst_n = 1'b0; src_req = '0; src_mask = '0; gset = 0; gclr = 0; gret = 0;
    m_irq = 0; m_gie = 0; m_vec = BASE; m_pend = '0;
    repeat (3) @(negedge clk);
    chk("R1 irq in reset", 32'(irq), 0);
    chk("R1 gie in reset", 32'(gie), 0);
    chk("R1 pend in reset", 32'(pend), 0);
    chk("R1 vec in reset", 32'(vec), 32'(BASE));
    rst_n = 1'b1;
    repeat (3) step('0, '0, 0, 0, 0);

    // R2: requests latch while globally off and masked
    step(8'b1010_0100, '0, 0, 0, 0);
    step('0, 8'hFF, 0, 0, 0);
    chk("R2 held while off", 32'(pend), 32'h0A4);
    chk("R3 no irq while off", 32'(irq), 0);
    // R9: set and clear together, clear wins
    step('0, 8'hFF, 1, 1, 0);
    chk("R9 clear beats set", 32'(gie), 0);
    step('0, 8'hFF, 1, 0, 0);
    chk("R9 set", 32'(gie), 1);
    step('0, 8'hFF, 0, 0, 0);
    chk("R4 R5 lowest source 2", 32'(vec), 32'(vec_of(2)));
    chk("R6 irq pulse", 32'(irq), 1);
    chk("R6 gie cleared", 32'(gie), 0);
    chk("R7 winner cleared only", 32'(pend), 32'h0A0);
    step('0, 8'hFF, 0, 0, 0);
    chk("R6 single cycle pulse", 32'(irq), 0);
    chk("R10 vector held", 32'(vec), 32'(vec_of(2)));
    // R8: return re-enables, next source taken
    step('0, 8'hFF, 0, 0, 1);
    chk("R8 return sets gie", 32'(gie), 1);
    step(8'b0010_0000, 8'hFF, 0, 0, 0);
    chk("R5 source 5 vector", 32'(vec), 32'(vec_of(5)));
    chk("R7 re-request kept", 32'(pend), 32'h0A0);
    // R3: masked source ignored, flag kept
    step('0, 8'b0101_1111, 0, 0, 1);
    step('0, 8'b0101_1111, 0, 0, 0);
    chk("R3 masked not taken", 32'(irq), 0);
    chk("R2 masked flag kept", 32'(pend), 32'h0A0);
    chk("R8 gie still on", 32'(gie), 1);
    step('0, 8'hFF, 0, 1, 0);

    // constrained random
    for (int i = 0; i < 4000; i++) begin
      rq = '0;
      for (int b = 0; b < N; b++) rq[b] = ($urandom % 10) == 0;
      mk = 8'($urandom);
      step(rq, mk, ($urandom % 12) == 0, ($urandom % 25) == 0, ($urandom % 8) == 0);
    end
    done = 1;
    finish_run();
  end
endmodule